// File: doc/BRIEF.md
# Delayed Pulse Generator with Narrow-Trigger Capture

This block turns a falling edge on an asynchronous, active-low trigger line into a single clean output pulse. After the trigger, it waits a programmed number of clock cycles and then holds its output high for a second programmed number of cycles. The trigger may be much narrower than a clock period. A flag with an asynchronous set catches it, a synchroniser chain brings the flag into the clock domain, and an edge detector turns it into a one-cycle event. Everything after the capture flag runs on the rising clock edge.

The delay and width are sampled at the moment the event is taken. Changing those inputs later affects only the next trigger. A controller with three phases (idle, counting the delay, driving the pulse) owns two counters that run one after the other. A busy flag covers both active phases. The block ignores triggers that arrive while it is busy.

Top module: `dly_pulse_gen`

## Requirements
- R1: A falling edge on `start_n_i`, even one whose low time is shorter than a clock period, is taken as a trigger on the third rising clock edge after the fall (the first edge after the fall counts as one). `busy_o` is high from that edge onward while the trigger is in service.
- R2: With a sampled delay D of at least 1, `pulse_o` rises D clock edges after the edge on which the trigger was taken. `busy_o` stays high throughout those D cycles.
- R3: With a sampled delay of 0 and a non-zero width, `pulse_o` rises on the same edge on which the trigger is taken.
- R4: With a sampled width W of at least 1, `pulse_o` stays high for exactly W clock cycles. It then falls together with `busy_o`, and it is never high while `busy_o` is low.
- R5: A sampled width of 0 produces no pulse. With delay D > 0, `busy_o` is high for D cycles only. With delay 0, `busy_o` never rises.
- R6: `delay_i` and `width_i` are sampled only on the edge where the trigger is taken. Changes to them while busy do not alter the pulse in progress.
- R7: A falling edge on `start_n_i` whose trigger would be taken while `busy_o` is high is discarded. It produces no second pulse, either then or afterwards.
- R8: A synchronous reset (`rst_i` high at a rising edge) drives `pulse_o` and `busy_o` low after that edge. It also discards any trigger that has been captured but not yet taken.
- R9: The full input ranges are honoured: a delay of 4095 and a width of 8191 give exactly those counts.
- R10: Holding `start_n_i` low for several clock cycles yields exactly one trigger, taken at the same edge as for a narrow pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Rising-edge clock |
| rst_i | input | 1 | Synchronous reset, active high |
| start_n_i | input | 1 | Asynchronous trigger, active on its falling edge |
| delay_i | input | DLY_W (12) | Delay in clock cycles before the pulse |
| width_i | input | WID_W (13) | Pulse length in clock cycles |
| pulse_o | output | 1 | Registered output pulse |
| busy_o | output | 1 | High during the delay and pulse phases |

## Verification
The bench aims at the counting edges. A delay of 0 must start the pulse on the trigger edge itself; an off-by-one counter would delay it by a cycle or drop it. A width of 0 must yield no pulse; a counter that wraps would instead emit a pulse thousands of cycles long. The extreme values 4095 and 8191 expose counters that are one bit too narrow or that stop one short. The bench also changes the inputs mid-pulse, retriggers while busy, holds the trigger low across several edges and resets with a captured event still pending. A design that samples its inputs late, restarts on a retrigger, fires twice on a long low, or lets a stale capture survive reset would show an extra, shifted or stretched pulse against the cycle model.

// File: rtl/dpg_pkg.sv
package dpg_pkg;

   typedef enum logic [1:0] {
      DPG_IDLE  = 2'd0,
      DPG_DELAY = 2'd1,
      DPG_PULSE = 2'd2
   } dpg_state_e;

endpackage

// File: rtl/dpg_capture.sv
module dpg_capture #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_i,
   input  logic start_n_i,
   output logic event_o
);

   logic flag_q;
   logic synced;
   logic seen_q;

   // Flag set asynchronously by the low level of the trigger, cleared on the clock.
   always_ff @(posedge clk_i or negedge start_n_i) begin
      if (!start_n_i) begin
         flag_q <= 1'b1;
      end else if (rst_i || synced) begin
         flag_q <= 1'b0;
      end
   end

   generate
      if (SYNC_STAGES == 1) begin : g_single
         logic stage_q;
         always_ff @(posedge clk_i) begin
            if (rst_i) stage_q <= 1'b0;
            else       stage_q <= flag_q;
         end
         assign synced = stage_q;
      end else begin : g_chain
         logic [SYNC_STAGES-1:0] chain_q;
         always_ff @(posedge clk_i) begin
            if (rst_i) chain_q <= '0;
            else       chain_q <= {chain_q[SYNC_STAGES-2:0], flag_q};
         end
         assign synced = chain_q[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk_i) begin
      if (rst_i) seen_q <= 1'b0;
      else       seen_q <= synced;
   end

   assign event_o = synced & ~seen_q;

endmodule

// File: rtl/dpg_cnt.sv
module dpg_cnt #(
   parameter int W = 12
) (
   input  logic         clk_i,
   input  logic         rst_i,
   input  logic         load_i,
   input  logic         step_i,
   input  logic [W-1:0] limit_i,
   output logic         hit_o
);

   logic [W-1:0] cnt_q;

   // Loads one on phase entry so that the count equals cycles spent in the phase.
   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         cnt_q <= '0;
      end else if (load_i) begin
         cnt_q <= W'(1);
      end else if (step_i) begin
         cnt_q <= cnt_q + W'(1);
      end
   end

   assign hit_o = (cnt_q == limit_i);

endmodule

// File: rtl/dly_pulse_gen.sv
module dly_pulse_gen
   import dpg_pkg::*;
#(
   parameter int DLY_W       = 12,
   parameter int WID_W       = 13,
   parameter int DLY_RST     = 10,
   parameter int WID_RST     = 4700,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             start_n_i,
   input  logic [DLY_W-1:0] delay_i,
   input  logic [WID_W-1:0] width_i,
   output logic             pulse_o,
   output logic             busy_o
);

   localparam logic [DLY_W-1:0] DLY_INIT = DLY_W'(DLY_RST);
   localparam logic [WID_W-1:0] WID_INIT = WID_W'(WID_RST);

   initial begin
      assert (DLY_W >= 1 && DLY_W <= 31) else $error("DLY_W out of range");
      assert (WID_W >= 1 && WID_W <= 31) else $error("WID_W out of range");
      assert (SYNC_STAGES >= 1) else $error("SYNC_STAGES must be at least 1");
      assert (DLY_RST >= 0 && DLY_RST < (1 << DLY_W)) else $error("DLY_RST does not fit");
      assert (WID_RST >= 0 && WID_RST < (1 << WID_W)) else $error("WID_RST does not fit");
   end

   logic             evt;
   dpg_state_e       st_q, st_d;
   logic [DLY_W-1:0] dly_q;
   logic [WID_W-1:0] wid_q;
   logic             d_load, d_step, d_hit;
   logic             w_load, w_step, w_hit;
   logic             pulse_q, busy_q;
   logic             take;

   dpg_capture #(.SYNC_STAGES(SYNC_STAGES)) u_cap (
      .clk_i     (clk_i),
      .rst_i     (rst_i),
      .start_n_i (start_n_i),
      .event_o   (evt)
   );

   dpg_cnt #(.W(DLY_W)) u_dcnt (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .load_i  (d_load),
      .step_i  (d_step),
      .limit_i (dly_q),
      .hit_o   (d_hit)
   );

   dpg_cnt #(.W(WID_W)) u_wcnt (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .load_i  (w_load),
      .step_i  (w_step),
      .limit_i (wid_q),
      .hit_o   (w_hit)
   );

   assign take = (st_q == DPG_IDLE) && evt;

   always_comb begin
      st_d   = st_q;
      d_load = 1'b0;
      d_step = 1'b0;
      w_load = 1'b0;
      w_step = 1'b0;
      case (st_q)
         DPG_IDLE: begin
            if (evt) begin
               if (delay_i != '0) begin
                  st_d   = DPG_DELAY;
                  d_load = 1'b1;
               end else if (width_i != '0) begin
                  st_d   = DPG_PULSE;
                  w_load = 1'b1;
               end
            end
         end
         DPG_DELAY: begin
            if (d_hit) begin
               if (wid_q != '0) begin
                  st_d   = DPG_PULSE;
                  w_load = 1'b1;
               end else begin
                  st_d = DPG_IDLE;
               end
            end else begin
               d_step = 1'b1;
            end
         end
         DPG_PULSE: begin
            if (w_hit) st_d = DPG_IDLE;
            else       w_step = 1'b1;
         end
         default: st_d = DPG_IDLE;
      endcase
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         st_q    <= DPG_IDLE;
         dly_q   <= DLY_INIT;
         wid_q   <= WID_INIT;
         pulse_q <= 1'b0;
         busy_q  <= 1'b0;
      end else begin
         st_q    <= st_d;
         pulse_q <= (st_d == DPG_PULSE);
         busy_q  <= (st_d != DPG_IDLE);
         if (take) begin
            dly_q <= delay_i;
            wid_q <= width_i;
         end
      end
   end

   assign pulse_o = pulse_q;
   assign busy_o  = busy_q;

endmodule

// File: rtl/dpg_chk.sv
module dpg_chk #(
   parameter int DLY_W = 12,
   parameter int WID_W = 13
) (
   input logic             clk_i,
   input logic             rst_i,
   input logic             pulse_o,
   input logic             busy_o,
   input logic [DLY_W-1:0] dly_q,
   input logic [WID_W-1:0] wid_q
);

   // R4
   pulse_needs_busy_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      pulse_o |-> busy_o);

   // R4
   pulse_end_idle_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      $fell(pulse_o) |-> !busy_o);

   // R8
   reset_quiet_chk: assert property (@(posedge clk_i)
      rst_i |=> (!pulse_o && !busy_o));

   // R6
   latch_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (busy_o && $past(busy_o)) |-> ($stable(dly_q) && $stable(wid_q)));

   // R5
   zero_width_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      $rose(pulse_o) |-> (wid_q != '0));

   // R3
   direct_start_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      ($rose(busy_o) && pulse_o) |-> (dly_q == '0));

endmodule

bind dly_pulse_gen dpg_chk #(.DLY_W(DLY_W), .WID_W(WID_W)) u_chk (
   .clk_i   (clk_i),
   .rst_i   (rst_i),
   .pulse_o (pulse_o),
   .busy_o  (busy_o),
   .dly_q   (dly_q),
   .wid_q   (wid_q)
);

// File: tb/dly_pulse_gen_tb.sv
module dly_pulse_gen_tb;

   logic        clk_i = 1'b0;
   logic        rst_i = 1'b0;
   logic        start_n_i = 1'b1;
   logic [11:0] delay_i = 12'd0;
   logic [12:0] width_i = 13'd0;
   logic        pulse_o, busy_o;

   int    n_checks = 0;
   int    n_errors = 0;
   bit    checking = 1'b0;
   bit    done = 1'b0;
   string cur_req = "R8";

   // reference model state: 0 idle, 1 delay, 2 pulse
   int ecount = 0;
   int take_edge = -1;
   int m_state = 0;
   int dleft = 0, wleft = 0, m_w = 0;
   int pulses_seen = 0;

   always #4 clk_i = ~clk_i;

   dly_pulse_gen u_dut (
      .clk_i     (clk_i),
      .rst_i     (rst_i),
      .start_n_i (start_n_i),
      .delay_i   (delay_i),
      .width_i   (width_i),
      .pulse_o   (pulse_o),
      .busy_o    (busy_o)
   );

   always @(negedge start_n_i) take_edge = ecount + 3;

   always @(posedge clk_i) begin
      bit idle_before;
      ecount++;
      if (rst_i) begin
         m_state   = 0;
         take_edge = -1;
      end else begin
         idle_before = (m_state == 0);
         if (m_state == 1) begin
            dleft--;
            if (dleft == 0) begin
               if (m_w > 0) begin m_state = 2; wleft = m_w; end
               else m_state = 0;
            end
         end else if (m_state == 2) begin
            wleft--;
            if (wleft == 0) m_state = 0;
         end
         if (take_edge == ecount) begin
            take_edge = -1;
            if (idle_before) begin
               m_w = int'(width_i);
               if (delay_i == 0) begin
                  if (m_w > 0) begin m_state = 2; wleft = m_w; end
               end else begin
                  m_state = 1;
                  dleft = int'(delay_i);
               end
            end
         end
      end
   end

   task automatic check(input string what, input logic act, input logic exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s %s at edge %0d: actual %b expected %b", cur_req, what, ecount, act, exp);
      end
   endtask

   always @(negedge clk_i) begin
      if (checking) begin
         check("pulse_o", pulse_o, m_state == 2);
         check("busy_o", busy_o, m_state != 0);
      end
      if (pulse_o && !checking) pulses_seen = pulses_seen;
   end

   // count rising edges of the output pulse for directed checks
   logic pulse_prev = 1'b0;
   always @(negedge clk_i) begin
      if (pulse_o === 1'b1 && pulse_prev !== 1'b1) pulses_seen++;
      pulse_prev <= pulse_o;
   end

   task automatic cycles(input int n);
      repeat (n) @(negedge clk_i);
   endtask

   task automatic fire();
      @(negedge clk_i);
      #1 start_n_i = 1'b0;
      #2 start_n_i = 1'b1;
   endtask

   task automatic expect_count(input string req, input int exp);
      cur_req = req;
      n_checks++;
      if (pulses_seen != exp) begin
         n_errors++;
         $display("FAIL %s pulse count: actual %0d expected %0d", req, pulses_seen, exp);
      end
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         n_errors++;
         $display("FAIL watchdog expired in %s", cur_req);
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
         $finish;
      end
   end

   initial begin
      // R8: reset state
      rst_i = 1'b1;
      cycles(3);
      checking = 1'b1;
      cycles(2);
      rst_i = 1'b0;
      cycles(4);

      // R1, R2: normal delay and width
      cur_req = "R2";
      delay_i = 12'd5; width_i = 13'd7;
      fire(); cycles(30);
      expect_count("R1", 1);

      // R3: zero delay
      cur_req = "R3";
      delay_i = 12'd0; width_i = 13'd4;
      fire(); cycles(20);
      expect_count("R3", 2);

      // R4: one-cycle and long widths
      cur_req = "R4";
      delay_i = 12'd3; width_i = 13'd1;
      fire(); cycles(20);
      delay_i = 12'd10; width_i = 13'd4700;
      fire(); cycles(4730);
      expect_count("R4", 4);

      // R5: zero width, with and without delay
      cur_req = "R5";
      delay_i = 12'd6; width_i = 13'd0;
      fire(); cycles(20);
      delay_i = 12'd0;
      fire(); cycles(20);
      expect_count("R5", 4);

      // R6: inputs change during the pulse
      cur_req = "R6";
      delay_i = 12'd4; width_i = 13'd10;
      fire(); cycles(5);
      delay_i = 12'd1; width_i = 13'd1;
      cycles(30);
      expect_count("R6", 5);

      // R7: retrigger while busy
      cur_req = "R7";
      delay_i = 12'd20; width_i = 13'd5;
      fire(); cycles(10);
      fire(); cycles(50);
      expect_count("R7", 6);

      // R8: reset mid-pulse, then reset with a pending capture
      cur_req = "R8";
      delay_i = 12'd2; width_i = 13'd50;
      fire(); cycles(15);
      rst_i = 1'b1; cycles(1); rst_i = 1'b0;
      cycles(60);
      fire();
      rst_i = 1'b1; cycles(1); rst_i = 1'b0;
      cycles(30);
      expect_count("R8", 7);

      // R10: trigger held low for several cycles
      cur_req = "R10";
      delay_i = 12'd3; width_i = 13'd3;
      @(negedge clk_i);
      #1 start_n_i = 1'b0;
      cycles(5);
      #1 start_n_i = 1'b1;
      cycles(30);
      expect_count("R10", 8);

      // R9: full-range values
      cur_req = "R9";
      delay_i = 12'd4095; width_i = 13'd8191;
      fire(); cycles(4095 + 8191 + 20);
      expect_count("R9", 9);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

endmodule